// File: doc/BRIEF.md
# Display Pad Output Router

This block sits between the serializers of a display interface and its output pads. A bank of serialized data channels arrives on every bit-clock edge. Each pad has one control word that picks which channel, if any, reaches that pad's pins. The control word also sets the sense of each pin, whether the pin is shifted by half a bit period, whether the pad drives at all, and whether the pad works as a complementary pair or as two independent single-ended pins.

In pair mode, the P pin of pad i carries channel i or channel i-1, and the N pin always carries the complement of P. In single-ended mode, the pad carries two channels on separate pins. The P pin chooses between channel 2i and channel 2i-1. The N pin chooses between channel 2i+1 and channel 2i. Either pin can instead carry a forwarded clock pattern or a constant zero. The drive-strength field is kept in the register and can be read back, but it has no effect on the pins.

Control words sit at consecutive word indices, one per pad. They are written and read through a simple synchronous write port and a combinational read port.

Top module: `pad_router`

## Requirements
- R1: While the reset is active, and on the rising edge at which the internal reset is released, every control word is zero. In this state `p_out` is 0, `n_out` is 1 and `oe_out` is 0 for all pads. The internal reset is released on the second rising edge after `rst_n` goes high.
- R2: A write to index k below NUM_PADS stores `wr_data & 0x001E60F3`, so only bits 20:17, 14:13, 7:4 and 1:0 are kept, and the stored word can be read at `rd_data` in the next cycle. A write to an index at or above NUM_PADS changes nothing, and reading such an index returns 0.
- R3: In pair mode (bit 4 = 0), the P source select in bits 18:17 works as follows: 00 picks channel i, 01 picks channel i-1, 10 picks the clock pattern and 11 picks 0. A channel index that falls outside 0..2*NUM_PADS-1 reads as 0.
- R4: In single-ended mode (bit 4 = 1), the P source select works as follows: 00 picks channel 2i, 01 picks channel 2i-1, 10 picks the clock pattern and 11 picks 0.
- R5: In single-ended mode, the N source select in bits 20:19 works as follows: 00 picks channel 2i+1, 01 picks channel 2i, 10 picks the clock pattern and 11 picks 0. In pair mode this field has no effect.
- R6: The P invert bit (bit 5) inverts the P pin when it is 1 in single-ended mode, and when it is 0 in pair mode. The N invert bit (bit 6) inverts the N pin when it is 1, and only in single-ended mode.
- R7: In pair mode, `n_out` is always the complement of `p_out`.
- R8: The source value present at a rising edge reaches an undelayed pin right after that edge. With the P delay bit (bit 13) set, or the N delay bit (bit 14) set, that pin instead changes at the following falling edge. The N delay bit acts only in single-ended mode; in pair mode the N pin follows the P delay.
- R9: `oe_out` of a pad equals bit 7 of its control word. It changes right after the edge that writes the word.
- R10: The drive-strength bits (1:0) can be read back but leave `p_out`, `n_out` and `oe_out` unchanged.
- R11: The clock pattern is a bit that is 0 at the first active rising edge and inverts on every rising edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | 2*NUM_PADS | Serialized channel bits |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | ADDR_W | Word index of the write |
| wr_data | input | 32 | Control word value |
| rd_addr | input | ADDR_W | Word index of the read |
| rd_data | output | 32 | Stored control word |
| p_out | output | NUM_PADS | P pin value per pad |
| n_out | output | NUM_PADS | N pin value per pad |
| oe_out | output | NUM_PADS | Output enable per pad |

## Verification
The bench builds the block with NUM_PADS = 4 and ADDR_W = 4. With these values, pad 0 uses the out-of-range channel i-1 and channel 2i-1, pad 3 uses the top channel 2i+1, and word indices 4 to 15 are free for writes that must be ignored. Each cycle the bench samples twice: once between the rising and falling edge, and once just before the next rising edge. This separates delayed pins from undelayed ones. Sweeps over every select code in both modes run first, followed by a long run of random writes.

// File: rtl/pad_router_pkg.sv
package pad_router_pkg;

  // Bit positions inside a pad control word
  localparam int F_NSEL_HI = 20;
  localparam int F_NSEL_LO = 19;
  localparam int F_PSEL_HI = 18;
  localparam int F_PSEL_LO = 17;
  localparam int F_NDLY    = 14;
  localparam int F_PDLY    = 13;
  localparam int F_OE      = 7;
  localparam int F_NPOL    = 6;
  localparam int F_PPOL    = 5;
  localparam int F_MODE    = 4;

  // Bits that are actually stored
  localparam logic [31:0] CFG_MASK = 32'h001E_60F3;

  typedef enum logic [1:0] {
    SRC_NEAR = 2'b00,
    SRC_ALT  = 2'b01,
    SRC_CLK  = 2'b10,
    SRC_ZERO = 2'b11
  } src_sel_e;

  // Fields that influence the pins (drive strength excluded)
  typedef struct packed {
    src_sel_e nsel;
    src_sel_e psel;
    logic     ndly;
    logic     pdly;
    logic     oe;
    logic     npol;
    logic     ppol;
    logic     single;
  } pin_cfg_t;

endpackage

// File: rtl/pad_rst_sync.sv
module pad_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_router_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [31:0]               rd_data,
  output pin_cfg_t [NUM_PADS-1:0]   cfg_o
);

  logic [NUM_PADS-1:0][31:0] word_q, word_d;

  // next-state
  always_comb begin
    word_d = word_q;
    for (int k = 0; k < NUM_PADS; k++) begin
      if (wr_addr == ADDR_W'(k)) word_d[k] = wr_data & CFG_MASK;
    end
  end

  // register with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= word_d;
  end

  // read port
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_PADS; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_data = word_q[k];
    end
  end

  // field decode
  for (genvar g = 0; g < NUM_PADS; g++) begin : g_dec
    assign cfg_o[g].nsel   = src_sel_e'(word_q[g][F_NSEL_HI:F_NSEL_LO]);
    assign cfg_o[g].psel   = src_sel_e'(word_q[g][F_PSEL_HI:F_PSEL_LO]);
    assign cfg_o[g].ndly   = word_q[g][F_NDLY];
    assign cfg_o[g].pdly   = word_q[g][F_PDLY];
    assign cfg_o[g].oe     = word_q[g][F_OE];
    assign cfg_o[g].npol   = word_q[g][F_NPOL];
    assign cfg_o[g].ppol   = word_q[g][F_PPOL];
    assign cfg_o[g].single = word_q[g][F_MODE];
  end

endmodule

// File: rtl/pad_lane.sv
module pad_lane
  import pad_router_pkg::*;
#(
  parameter int PAD_IDX = 0,
  parameter int NUM_CH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pin_cfg_t          cfg,
  input  logic [NUM_CH-1:0] chan,
  input  logic              clk_pat,
  output logic              p_pin,
  output logic              n_pin,
  output logic              oe
);

  // Indices into the zero-padded vector: entry 0 stands for "below range"
  localparam int DIF_NEAR = PAD_IDX + 1;
  localparam int DIF_ALT  = PAD_IDX;
  localparam int SEP_NEAR = 2 * PAD_IDX + 1;
  localparam int SEP_ALT  = 2 * PAD_IDX;
  localparam int SEN_NEAR = 2 * PAD_IDX + 2;
  localparam int SEN_ALT  = 2 * PAD_IDX + 1;

  logic [NUM_CH:0] ext;
  assign ext = {chan, 1'b0};

  function automatic logic pick(src_sel_e s, logic near, logic alt, logic pat);
    case (s)
      SRC_NEAR: pick = near;
      SRC_ALT:  pick = alt;
      SRC_CLK:  pick = pat;
      default:  pick = 1'b0;
    endcase
  endfunction

  logic p_src, p_nxt, n_nxt;
  logic p_rise_q, n_rise_q, p_fall_q, n_fall_q;
  logic n_single;

  // next-state
  always_comb begin
    if (cfg.single) p_src = pick(cfg.psel, ext[SEP_NEAR], ext[SEP_ALT], clk_pat);
    else            p_src = pick(cfg.psel, ext[DIF_NEAR], ext[DIF_ALT], clk_pat);
    p_nxt = p_src ^ (cfg.single ? cfg.ppol : ~cfg.ppol);
    n_nxt = pick(cfg.nsel, ext[SEN_NEAR], ext[SEN_ALT], clk_pat) ^ cfg.npol;
  end

  // rising-edge capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rise_q <= 1'b0;
      n_rise_q <= 1'b0;
    end else begin
      p_rise_q <= p_nxt;
      n_rise_q <= n_nxt;
    end
  end

  // half-period retiming on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_fall_q <= 1'b0;
      n_fall_q <= 1'b0;
    end else begin
      p_fall_q <= p_rise_q;
      n_fall_q <= n_rise_q;
    end
  end

  // pin selection
  always_comb begin
    p_pin    = cfg.pdly ? p_fall_q : p_rise_q;
    n_single = cfg.ndly ? n_fall_q : n_rise_q;
    n_pin    = cfg.single ? n_single : ~p_pin;
    oe       = cfg.oe;
  end

endmodule

// File: rtl/pad_router.sv
module pad_router
  import pad_router_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_PADS-1:0] chan_in,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [31:0]           rd_data,
  output logic [NUM_PADS-1:0]   p_out,
  output logic [NUM_PADS-1:0]   n_out,
  output logic [NUM_PADS-1:0]   oe_out
);

  localparam int NUM_CH = 2 * NUM_PADS;

  logic                      rst_int_n;
  pin_cfg_t [NUM_PADS-1:0]   cfg_d;
  logic                      pat_q, pat_d;

  pad_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  pad_cfg_regs #(
    .NUM_PADS (NUM_PADS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_o   (cfg_d)
  );

  // forwarded clock pattern: inverts every bit period
  always_comb pat_d = ~pat_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pat_q <= 1'b0;
    else            pat_q <= pat_d;
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    pad_lane #(
      .PAD_IDX (g),
      .NUM_CH  (NUM_CH)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cfg     (cfg_d[g]),
      .chan    (chan_in),
      .clk_pat (pat_q),
      .p_pin   (p_out[g]),
      .n_pin   (n_out[g]),
      .oe      (oe_out[g])
    );
  end

endmodule

// File: rtl/pad_router_chk.sv
module pad_router_chk
  import pad_router_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int ADDR_W   = 4
) (
  input logic                  clk,
  input logic                  rst_int_n,
  input logic [2*NUM_PADS-1:0] chan_in,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic                  wr_oe,
  input pin_cfg_t [NUM_PADS-1:0] cfg_d,
  input logic [NUM_PADS-1:0]   p_out,
  input logic [NUM_PADS-1:0]   n_out,
  input logic [NUM_PADS-1:0]   oe_out
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed_q <= 1'b0;
    else            armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_chk
    // R9
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en && wr_addr == ADDR_W'(g)) |=>
        (oe_out[g] == $past(wr_oe)) && (cfg_d[g].oe == oe_out[g]));

    // R7
    pair_complement_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      !cfg_d[g].single |-> (n_out[g] == ~p_out[g]));

    // R3
    pair_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (armed_q && !cfg_d[g].pdly && $past(!cfg_d[g].single && cfg_d[g].psel == SRC_ZERO))
        |-> (p_out[g] == ~$past(cfg_d[g].ppol)));

    // R4
    single_p_near_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (armed_q && !cfg_d[g].pdly && $past(cfg_d[g].single && cfg_d[g].psel == SRC_NEAR))
        |-> (p_out[g] == ($past(chan_in[2*g]) ^ $past(cfg_d[g].ppol))));

    // R5
    single_n_near_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (armed_q && cfg_d[g].single && !cfg_d[g].ndly &&
       $past(cfg_d[g].single && cfg_d[g].nsel == SRC_NEAR))
        |-> (n_out[g] == ($past(chan_in[2*g+1]) ^ $past(cfg_d[g].npol))));
  end

endmodule

bind pad_router pad_router_chk #(
  .NUM_PADS (NUM_PADS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .chan_in   (chan_in),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_oe     (wr_data[pad_router_pkg::F_OE]),
  .cfg_d     (cfg_d),
  .p_out     (p_out),
  .n_out     (n_out),
  .oe_out    (oe_out)
);

// File: tb/tb_pad_router.sv
`timescale 1ns/100ps
module tb_pad_router;

  localparam int NP = 4;
  localparam int AW = 4;
  localparam int NC = 2 * NP;
  localparam logic [31:0] MASK = 32'h001E_60F3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] chan_in;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic [NP-1:0] p_out, n_out, oe_out;

  always #2 clk = ~clk;

  pad_router #(.NUM_PADS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .p_out(p_out), .n_out(n_out), .oe_out(oe_out)
  );

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [31:0] cfg_m [NP];
  bit cur_p [NP], prev_p [NP], cur_n [NP], prev_n [NP];
  bit pat_m;

  // staged write
  bit          st_en;
  logic [AW-1:0] st_addr;
  logic [31:0] st_data;

  function automatic bit chb(int k);
    return (k >= 0 && k < NC) ? chan_in[k] : 1'b0;
  endfunction

  function automatic bit srcpick(int s, int near, int alt);
    case (s)
      0: return chb(near);
      1: return chb(alt);
      2: return pat_m;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(int nsel, int psel, bit ndly, bit pdly,
                                     bit oe, bit npol, bit ppol, bit single, int boost);
    logic [31:0] w = '0;
    w[20:19] = 2'(nsel); w[18:17] = 2'(psel);
    w[14] = ndly; w[13] = pdly; w[7] = oe; w[6] = npol; w[5] = ppol; w[4] = single;
    w[1:0] = 2'(boost);
    return w;
  endfunction

  task automatic model_edge();
    for (int i = 0; i < NP; i++) begin
      logic [31:0] c = cfg_m[i];
      bit pv, nv;
      if (c[4]) pv = srcpick(int'(c[18:17]), 2*i, 2*i-1) ^ c[5];
      else      pv = srcpick(int'(c[18:17]), i, i-1) ^ !c[5];
      nv = srcpick(int'(c[20:19]), 2*i+1, 2*i) ^ c[6];
      prev_p[i] = cur_p[i]; cur_p[i] = pv;
      prev_n[i] = cur_n[i]; cur_n[i] = nv;
    end
    if (wr_en && int'(wr_addr) < NP) cfg_m[int'(wr_addr)] = wr_data & MASK;
    pat_m = !pat_m;
  endtask

  task automatic compare(bit early, string tag);
    logic [NP-1:0] ep, en, eo;
    for (int i = 0; i < NP; i++) begin
      logic [31:0] c = cfg_m[i];
      ep[i] = (c[13] && early) ? prev_p[i] : cur_p[i];
      if (c[4]) en[i] = (c[14] && early) ? prev_n[i] : cur_n[i];
      else      en[i] = !ep[i];
      eo[i] = c[7];
    end
    checks++;
    if (p_out !== ep || n_out !== en || oe_out !== eo) begin
      fails++;
      $display("FAIL %s (%s) p=%b n=%b oe=%b expected p=%b n=%b oe=%b",
               tag, early ? "early" : "late", p_out, n_out, oe_out, ep, en, eo);
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_edge();
    #0.5;
    wr_en   = st_en;
    wr_addr = st_addr;
    wr_data = st_data;
    chan_in = NC'($urandom());
    st_en   = 1'b0;
    #1   compare(1'b1, tag);
    #2   compare(1'b0, tag);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) cycle(tag);
  endtask

  task automatic wr_cfg(int a, logic [31:0] d, string tag);
    st_en = 1'b1; st_addr = AW'(a); st_data = d;
    cycle(tag);
  endtask

  task automatic all_pads(logic [31:0] d, string tag);
    for (int p = 0; p < NP; p++) wr_cfg(p, d, tag);
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    rd_addr = AW'(a);
    #0.2;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s rd[%0d]=%h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; chan_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    st_en = 1'b0; st_addr = '0; st_data = '0;
    for (int i = 0; i < NP; i++) begin
      cfg_m[i] = '0; cur_p[i] = 0; prev_p[i] = 0; cur_n[i] = 0; prev_n[i] = 0;
    end
    pat_m = 1'b0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1.5;
    // R1 reset state
    checks++;
    if (p_out !== '0 || n_out !== '1 || oe_out !== '0) begin
      fails++;
      $display("FAIL R1 p=%b n=%b oe=%b expected p=0000 n=1111 oe=0000", p_out, n_out, oe_out);
    end
    for (int a = 0; a < NP; a++) rd_chk(a, 32'h0, "R1");

    run(20, "R6 R7 default pair mode");

    for (int s = 0; s < 4; s++) begin
      all_pads(mk(0, s, 0, 0, 1, 0, 1, 0, 0), "R3 R11 pair select");
      run(16, $sformatf("R3 R11 pair select %0d", s));
    end

    for (int ps = 0; ps < 4; ps++) begin
      for (int ns = 0; ns < 4; ns++) begin
        all_pads(mk(ns, ps, 0, 0, 1, ns[0], ps[1], 1, 0), "R4 R5 R6 single");
        run(8, $sformatf("R4 R5 R6 single p%0d n%0d", ps, ns));
      end
    end

    all_pads(mk(1, 0, 1, 0, 1, 1, 0, 0, 0), "R5 R6 R8 N fields in pair mode");
    run(16, "R5 R6 R8 N fields ignored in pair mode");

    wr_cfg(0, mk(0, 0, 1, 1, 1, 0, 0, 1, 0), "R8");
    wr_cfg(1, mk(0, 0, 0, 1, 1, 1, 0, 1, 0), "R8");
    wr_cfg(2, mk(0, 0, 1, 0, 1, 0, 1, 1, 0), "R8");
    wr_cfg(3, mk(2, 2, 1, 0, 1, 0, 0, 1, 0), "R8");
    run(20, "R8 single delays");

    all_pads(mk(0, 0, 0, 1, 1, 0, 1, 0, 0), "R8 R7");
    run(16, "R8 R7 pair delay");

    wr_cfg(2, mk(0, 0, 0, 0, 0, 0, 1, 0, 0), "R9");
    run(4, "R9 pad released");
    wr_cfg(2, mk(0, 0, 0, 0, 1, 0, 1, 0, 0), "R9");
    run(4, "R9 pad driven");

    wr_cfg(1, mk(0, 1, 0, 0, 1, 0, 1, 0, 3), "R10");
    wr_cfg(3, mk(0, 1, 0, 0, 1, 0, 1, 0, 1), "R10");
    run(12, "R10 boost has no effect");
    rd_chk(1, mk(0, 1, 0, 0, 1, 0, 1, 0, 3), "R10");
    rd_chk(3, mk(0, 1, 0, 0, 1, 0, 1, 0, 1), "R10");

    wr_cfg(1, 32'hFFFF_FFFF, "R2");
    run(2, "R2");
    rd_chk(1, MASK, "R2");
    wr_cfg(9, 32'hFFFF_FFFF, "R2");
    run(6, "R2 out of range write ignored");
    rd_chk(9, 32'h0, "R2");
    rd_chk(0, mk(0, 0, 0, 1, 1, 0, 1, 0, 0), "R2");

    for (int k = 0; k < 1500; k++) begin
      if (($urandom() % 4) == 0) begin
        st_en = 1'b1;
        st_addr = AW'($urandom() % 6);
        st_data = $urandom();
      end
      cycle("R3 R4 R5 R6 R8 R9 random");
    end

    finish_run();
  end

endmodule